// File: doc/BRIEF.md
# Synchronous Character Hunt Detector

This block finds character boundaries in a synchronous serial receive stream. It runs on the receive bit clock, with one sample per bit. In internal mode it keeps a sliding window of the most recent bits. After every new bit it compares that window with one programmed sync character, or with a pair of them sent back to back. When the pattern is found, the detect flag rises and the block locks. The in-sync output then tells the downstream character assembler that the bit that follows starts a character.

In external mode the detect pin becomes an input, so its output enable drops. A rising level on that pin locks the block at the next receive-clock edge, and the pin may then fall. Software clears the detect flag with a status-read strobe. A hunt strobe drops lock and starts a fresh bit-by-bit search.

Top module: `sync_hunt_detector`

## Requirements
- R1: While reset is asserted and after it is released, `sync_found` is 0, `in_sync` is 0 and `found_oe` is 1.
- R2: With `dual_pat`=0 in internal mode, `sync_found` and `in_sync` become 1 after the edge that samples the last bit of any CHAR_W-bit window equal to `sync_pat_a`. The first bit received compares with the MSB. The window may start at any bit offset.
- R3: A match is counted only when the window holds CHAR_W bits received since the last reset or hunt strobe. An all-zero pattern is therefore not found before the CHAR_W-th zero.
- R4: With `dual_pat`=1, `sync_found` rises only after the edge that samples the last bit of `sync_pat_b`, when that character immediately follows `sync_pat_a`. It is still 0 one bit earlier.
- R5: In dual mode, when the character after `sync_pat_a` differs from `sync_pat_b`, hunting returns to looking for `sync_pat_a`. The window that just failed is itself tested against `sync_pat_a`.
- R6: A `status_rd` strobe clears `sync_found` at the next edge unless a match sets it in the same cycle. `in_sync` is unaffected.
- R7: While `ext_mode`=1, `found_oe` is 0, `sync_found` is held at 0, internal matches cause no lock, and the bit window restarts empty.
- R8: In external mode, `in_sync` becomes 1 after the first edge at which `ext_sync_in` is sampled 1 having been sampled 0 at the previous edge. It stays 1 after the pin returns low.
- R9: A `hunt_start` strobe clears `in_sync` at the next edge and empties the bit window. It takes priority over a match or an external rise in the same cycle.
- R10: While locked, further occurrences of the sync pattern do not set `sync_found` again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_rx | input | 1 | Receive bit clock, rising edge samples |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit | input | 1 | Serial receive data |
| sync_pat_a | input | CHAR_W | First (or only) sync character |
| sync_pat_b | input | CHAR_W | Second sync character for dual mode |
| dual_pat | input | 1 | 1 selects the two-character pattern |
| ext_mode | input | 1 | 1 selects external synchronization |
| status_rd | input | 1 | Status-read strobe, clears the detect flag |
| hunt_start | input | 1 | Restart hunting, drop lock |
| ext_sync_in | input | 1 | Detect pin input level in external mode |
| sync_found | output | 1 | Detect flag driven onto the detect pin |
| found_oe | output | 1 | Output enable of the detect pin |
| in_sync | output | 1 | Character alignment established |

## Verification
The hardest case to reach is the dual-character relaunch. The first character must be followed by a copy of itself, so the window that fails the second-character test is the one that restarts the hunt. Only then does the true second character give a lock exactly one character later. The bench sends the first pattern twice and then the second pattern. It checks that the flag is still low one bit before the end of the final character and high on its last bit. A run of random bits, compared against the behavioural model on every cycle, covers matches at arbitrary offsets.

// File: rtl/sync_hunt_pkg.sv
package sync_hunt_pkg;
    typedef enum logic [1:0] {
        ST_HUNT_A = 2'd0,
        ST_HUNT_B = 2'd1,
        ST_LOCKED = 2'd2
    } hunt_state_e;
endpackage

// File: rtl/sync_window_cmp.sv
module sync_window_cmp #(
    parameter int CHAR_W = 8
) (
    input  logic [CHAR_W-1:0] window,
    input  logic [CHAR_W-1:0] pat_a,
    input  logic [CHAR_W-1:0] pat_b,
    output logic              hit_a,
    output logic              hit_b
);
    logic [CHAR_W-1:0] diff_a;
    logic [CHAR_W-1:0] diff_b;

    for (genvar i = 0; i < CHAR_W; i++) begin : g_bit
        assign diff_a[i] = window[i] ^ pat_a[i];
        assign diff_b[i] = window[i] ^ pat_b[i];
    end

    assign hit_a = ~|diff_a;
    assign hit_b = ~|diff_b;
endmodule

// File: rtl/ext_sync_edge.sv
module ext_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = pin;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign rise = pin & ~prev_q;
endmodule

// File: rtl/sync_hunt_detector.sv
module sync_hunt_detector
    import sync_hunt_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk_rx,
    input  logic              rst_n,
    input  logic              rx_bit,
    input  logic [CHAR_W-1:0] sync_pat_a,
    input  logic [CHAR_W-1:0] sync_pat_b,
    input  logic              dual_pat,
    input  logic              ext_mode,
    input  logic              status_rd,
    input  logic              hunt_start,
    input  logic              ext_sync_in,
    output logic              sync_found,
    output logic              found_oe,
    output logic              in_sync
);
    localparam int CW = $clog2(CHAR_W + 1);

    typedef struct packed {
        hunt_state_e       st;
        logic [CHAR_W-1:0] win;
        logic [CW-1:0]     fill;
        logic [CW-1:0]     bcnt;
        logic              flag;
    } regs_t;

    regs_t d, q;

    logic [CHAR_W-1:0] win_nx;
    logic              hit_a, hit_b, ext_rise, full, set_found;

    assign win_nx = {q.win[CHAR_W-2:0], rx_bit};
    assign full   = (q.fill >= CW'(CHAR_W - 1));

    sync_window_cmp #(.CHAR_W(CHAR_W)) cmp_i (
        .window (win_nx),
        .pat_a  (sync_pat_a),
        .pat_b  (sync_pat_b),
        .hit_a  (hit_a),
        .hit_b  (hit_b)
    );

    ext_sync_edge edge_i (
        .clk   (clk_rx),
        .rst_n (rst_n),
        .pin   (ext_sync_in),
        .rise  (ext_rise)
    );

    always_comb begin
        d         = q;
        set_found = 1'b0;
        d.win     = win_nx;
        d.fill    = (q.fill == CW'(CHAR_W)) ? q.fill : q.fill + CW'(1);
        if (ext_mode) begin
            d.fill = '0;
            d.bcnt = '0;
            d.flag = 1'b0;
            if (hunt_start)              d.st = ST_HUNT_A;
            else if (ext_rise)           d.st = ST_LOCKED;
            else if (q.st == ST_HUNT_B)  d.st = ST_HUNT_A;
        end else if (hunt_start) begin
            d.st   = ST_HUNT_A;
            d.fill = '0;
            d.bcnt = '0;
        end else begin
            case (q.st)
                ST_HUNT_A: begin
                    if (full && hit_a) begin
                        if (dual_pat) begin
                            d.st   = ST_HUNT_B;
                            d.bcnt = '0;
                        end else begin
                            set_found = 1'b1;
                        end
                    end
                end
                ST_HUNT_B: begin
                    if (q.bcnt == CW'(CHAR_W - 1)) begin
                        if (hit_b)      set_found = 1'b1;
                        else if (hit_a) d.bcnt    = '0;
                        else            d.st      = ST_HUNT_A;
                    end else begin
                        d.bcnt = q.bcnt + CW'(1);
                    end
                end
                default: ;
            endcase
            if (set_found) begin
                d.st   = ST_LOCKED;
                d.flag = 1'b1;
            end else if (status_rd) begin
                d.flag = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_rx or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= ST_HUNT_A;
            q.win  <= '0;
            q.fill <= '0;
            q.bcnt <= '0;
            q.flag <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign sync_found = q.flag;
    assign found_oe   = ~ext_mode;
    assign in_sync    = (q.st == ST_LOCKED);

    AST_FLAG_IMPLIES_LOCK: assert property (@(posedge clk_rx) disable iff (!rst_n)
        $rose(sync_found) |-> in_sync);                                          // R2
    AST_READ_CLEARS: assert property (@(posedge clk_rx) disable iff (!rst_n)
        (status_rd && in_sync && !hunt_start) |=> !sync_found);                  // R6
    AST_EXT_NO_FLAG: assert property (@(posedge clk_rx) disable iff (!rst_n)
        ext_mode |=> !sync_found);                                               // R7
    AST_EXT_RISE_LOCKS: assert property (@(posedge clk_rx) disable iff (!rst_n)
        (ext_mode && ext_rise && !hunt_start) |=> in_sync);                      // R8
    AST_HUNT_DROPS: assert property (@(posedge clk_rx) disable iff (!rst_n)
        hunt_start |=> !in_sync);                                                // R9
    AST_LOCK_HOLDS: assert property (@(posedge clk_rx) disable iff (!rst_n)
        (in_sync && !hunt_start) |=> in_sync);                                   // R10
    AST_NO_EARLY_MATCH: assert property (@(posedge clk_rx) disable iff (!rst_n)
        ($rose(in_sync) && !$past(ext_mode)) |-> ($past(q.fill) >= CW'(CHAR_W - 1))); // R3
endmodule

// File: tb/sync_hunt_detector_tb.sv
module sync_hunt_detector_tb_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         rx_bit, dual_pat, ext_mode, status_rd, hunt_start, ext_sync_in;
    logic [W-1:0] sync_pat_a, sync_pat_b;
    logic         sync_found, found_oe, in_sync;

    always #5 clk = ~clk;

    sync_hunt_detector #(.CHAR_W(W)) dut_i (
        .clk_rx      (clk),
        .rst_n       (rst_n),
        .rx_bit      (rx_bit),
        .sync_pat_a  (sync_pat_a),
        .sync_pat_b  (sync_pat_b),
        .dual_pat    (dual_pat),
        .ext_mode    (ext_mode),
        .status_rd   (status_rd),
        .hunt_start  (hunt_start),
        .ext_sync_in (ext_sync_in),
        .sync_found  (sync_found),
        .found_oe    (found_oe),
        .in_sync     (in_sync)
    );

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    done     = 0;
    string phase    = "R1";

    // behavioural reference model
    bit m_win[$];
    bit m_det, m_sync, m_second, m_prev;
    int m_cnt;

    function automatic bit win_eq(logic [W-1:0] pat);
        if (m_win.size() != W) return 1'b0;
        for (int i = 0; i < W; i++)
            if (m_win[i] != pat[W-1-i]) return 1'b0;
        return 1'b1;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_win.delete();
            m_det = 0; m_sync = 0; m_second = 0; m_prev = 0; m_cnt = 0;
        end else begin
            bit rise, set;
            rise   = ext_sync_in && !m_prev;
            m_prev = ext_sync_in;
            set    = 0;
            m_win.push_back(rx_bit);
            if (m_win.size() > W) void'(m_win.pop_front());
            if (ext_mode) begin
                m_win.delete();
                m_det = 0; m_second = 0;
                if (hunt_start) m_sync = 0;
                else if (rise)  m_sync = 1;
            end else if (hunt_start) begin
                m_win.delete();
                m_sync = 0; m_second = 0;
            end else begin
                if (!m_sync) begin
                    if (m_second) begin
                        m_cnt++;
                        if (m_cnt == W) begin
                            if (win_eq(sync_pat_b))      set = 1;
                            else if (win_eq(sync_pat_a)) m_cnt = 0;
                            else                         m_second = 0;
                        end
                    end else if (win_eq(sync_pat_a)) begin
                        if (dual_pat) begin m_second = 1; m_cnt = 0; end
                        else set = 1;
                    end
                end
                if (set) begin m_sync = 1; m_second = 0; m_det = 1; end
                else if (status_rd) m_det = 0;
            end
        end
    end

    task automatic chk(input logic act, input logic exp, input string tag, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(sync_found, m_det,     phase, "model sync_found");
            chk(in_sync,    m_sync,    phase, "model in_sync");
            chk(found_oe,   !ext_mode, phase, "model found_oe");
        end
    end

    task automatic send_bit(input logic b);
        rx_bit = b;
        @(negedge clk);
    endtask

    task automatic send_n(input logic [W-1:0] v, input int n);
        for (int i = W - 1; i >= W - n; i--) send_bit(v[i]);
    endtask

    task automatic strobe_hunt();
        hunt_start = 1'b1; @(negedge clk); hunt_start = 1'b0;
    endtask

    task automatic strobe_read();
        status_rd = 1'b1; @(negedge clk); status_rd = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst_n = 0; rx_bit = 0; dual_pat = 0; ext_mode = 0; status_rd = 0;
        hunt_start = 0; ext_sync_in = 0; sync_pat_a = 8'hA7; sync_pat_b = 8'h3C;
        repeat (3) @(negedge clk);
        chk(sync_found, 1'b0, "R1", "reset sync_found");
        chk(in_sync,    1'b0, "R1", "reset in_sync");
        chk(found_oe,   1'b1, "R1", "reset found_oe");
        rst_n = 1;
        @(negedge clk);
        chk(in_sync, 1'b0, "R1", "after release in_sync");

        phase = "R2";
        send_bit(1); send_bit(0); send_bit(1);
        send_n(8'hA7, 7);
        chk(in_sync, 1'b0, "R2", "one bit early");
        send_bit(1'b1);
        chk(sync_found, 1'b1, "R2", "single match flag");
        chk(in_sync,    1'b1, "R2", "single match lock");

        phase = "R6";
        strobe_read();
        chk(sync_found, 1'b0, "R6", "read clears flag");
        chk(in_sync,    1'b1, "R6", "read keeps lock");

        phase = "R10";
        send_n(8'hA7, 8);
        chk(sync_found, 1'b0, "R10", "no re-detect while locked");

        phase = "R9";
        strobe_hunt();
        chk(in_sync, 1'b0, "R9", "hunt drops lock");

        phase = "R3";
        sync_pat_a = 8'h00;
        strobe_hunt();
        send_n(8'h00, 7);
        chk(in_sync, 1'b0, "R3", "seven zeros not enough");
        send_bit(1'b0);
        chk(in_sync, 1'b1, "R3", "eighth zero locks");
        strobe_read();

        phase = "R5";
        sync_pat_a = 8'hA7; dual_pat = 1;
        strobe_hunt();
        send_n(8'hA7, 8); send_n(8'h55, 8);
        chk(in_sync, 1'b0, "R5", "wrong second char");
        send_n(8'hA7, 8); send_n(8'hA7, 8);
        chk(in_sync, 1'b0, "R5", "first char repeated");
        phase = "R4";
        send_n(8'h3C, 7);
        chk(sync_found, 1'b0, "R4", "one bit before end of second char");
        send_bit(1'b0);
        chk(sync_found, 1'b1, "R4", "dual match on last bit");
        chk(in_sync,    1'b1, "R5", "relaunch then lock");
        strobe_read();

        phase = "R2";
        dual_pat = 0;
        strobe_hunt();
        for (int k = 0; k < 600; k++) begin
            if (in_sync && (k % 5 == 0)) strobe_hunt();
            else if (k % 7 == 0) strobe_read();
            else send_bit(1'($urandom_range(0, 1)));
        end

        phase = "R7";
        ext_mode = 1;
        strobe_hunt();
        chk(found_oe, 1'b0, "R7", "pin turned to input");
        send_n(8'hA7, 8); send_n(8'hA7, 8);
        chk(in_sync,    1'b0, "R7", "internal hunt disabled");
        chk(sync_found, 1'b0, "R7", "flag held low");

        phase = "R8";
        ext_sync_in = 1;
        @(negedge clk);
        chk(in_sync, 1'b1, "R8", "external rise locks");
        ext_sync_in = 0;
        send_n(8'h12, 4);
        chk(in_sync, 1'b1, "R8", "lock kept after pin falls");
        strobe_hunt();
        chk(in_sync, 1'b0, "R9", "hunt drops external lock");
        ext_mode = 0;
        @(negedge clk);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end
endmodule